// File: doc/BRIEF.md
# Age-Ordered Clustered Issue Arbiter

This block is the selection stage of a small integer issue queue that feeds four execution sub-clusters, arranged as an upper pair (U0, U1) and a lower pair (L0, L1). Instructions arrive on a four-lane enqueue port. Each lane carries a class code, a pinned sub-cluster code and a ready bit. Every occupied, ready entry raises a request line for each sub-cluster its class allows. Two independent arbiters, one per pair, each hand out up to two grants per cycle with strict oldest-first priority. The block can therefore issue up to four entries per cycle.

Relative age is kept in an age matrix. A bit in row i, column j is set when entry j entered the queue before entry i. Rows are written on enqueue, and columns are cleared when an entry issues. Grants are formed only from registered queue state. Each grant output gives the index of the chosen entry, and a granted entry leaves the queue at the same clock edge. Operand wakeup is reduced to a per-entry wake vector that sets the ready bit of an occupied entry.

Top module: `iq_cluster_select`

## Requirements
- R1: After reset the queue is empty: every grant valid bit is 0 and `enq_ready_o` is 1.
- R2: `enq_ready_o` is 1 exactly when at least ENQ_W entries are unoccupied, counted before this cycle's issues. While it is 0, every enqueue lane is ignored and the number of occupied entries does not grow.
- R3: An accepted valid lane k takes the k-th lowest-numbered unoccupied entry. Idle lanes still use up their slot. This entry number is the one later reported on the grant index outputs.
- R4: The class code sets the request lines. Code 0 requests L0 and L1. Code 1 requests U0 and U1. Codes 2 and 3 request only the sub-cluster named by the pin code (0 U0, 1 U1, 2 L0, 3 L1). Grant slot s on the outputs serves sub-cluster s in that same numbering.
- R5: U0 and L0 are each granted to the oldest occupied, ready entry requesting them. Age follows the enqueue cycle, and within one cycle a lower-numbered lane is older.
- R6: U1 (L1) is granted to the oldest occupied, ready requester other than the entry granted U0 (L0) in the same cycle. No entry receives two grants in one cycle.
- R7: A granted entry becomes unoccupied at the next clock edge and is not granted again.
- R8: An entry that is not ready is never granted. A wake bit makes an occupied entry ready. An entry written in the same cycle takes its ready value from its lane and ignores the wake bit.
- R9: Grants depend only on registered state. Inputs applied in a cycle do not change that cycle's grants, so an entry is granted no earlier than the cycle after its enqueue.
- R10: The upper and lower arbiters work independently, so all four sub-clusters can be granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enq_vld_i | input | ENQ_W | Per-lane enqueue valid |
| enq_cls_i | input | ENQ_W x 2 | Per-lane class code |
| enq_pin_i | input | ENQ_W x 2 | Per-lane pinned sub-cluster code |
| enq_rdy_i | input | ENQ_W | Per-lane ready-at-enqueue bit |
| enq_ready_o | output | 1 | Enqueue accepted this cycle |
| wake_i | input | NUM_ENT | Per-entry ready set |
| gnt_vld_o | output | 4 | Grant valid per sub-cluster (U0, U1, L0, L1) |
| gnt_idx_o | output | 4 x IDX_W | Granted entry index per sub-cluster |

## Verification
The hardest situations to reach from the ports are the ones where enqueue order and readiness order disagree. Examples are a young entry becoming ready before older ones, and a queue nearly full when a refused enqueue arrives. Directed sequences build these cases. They enqueue entries that are not ready and wake them in reverse age order. They also fill the queue to one short of the acceptance threshold and then offer a full group of ready lanes. A long seeded random run then mixes class codes, pin codes, partial lane groups and sparse wake vectors so that the queue stays partly full. Throughout the run, every grant is compared against an age-ordered reference model kept in the bench.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;

    localparam int IQ_ENTRIES     = 20;
    localparam int IQ_ENQ_LANES   = 4;
    localparam int IQ_SUBCLUSTERS = 4;
    localparam int IQ_PAIRS       = IQ_SUBCLUSTERS / 2;

    // Class codes; both upper codes pin the entry to a single sub-cluster
    typedef enum logic [1:0] {
        CLS_LOWER      = 2'd0,
        CLS_UPPER      = 2'd1,
        CLS_PINNED     = 2'd2,
        CLS_PINNED_ALT = 2'd3
    } iq_class_e;

    // Per-entry payload held beside the occupancy bit
    typedef struct packed {
        logic      rdy;
        iq_class_e cls;
        logic [1:0] pin;
    } iq_entry_t;

    // Sub-cluster numbering: bit 0 U0, bit 1 U1, bit 2 L0, bit 3 L1
    function automatic logic [IQ_SUBCLUSTERS-1:0] class_lines(iq_class_e cls, logic [1:0] pin);
        logic [IQ_SUBCLUSTERS-1:0] lines;
        case (cls)
            CLS_LOWER: lines = 4'b1100;
            CLS_UPPER: lines = 4'b0011;
            default:   lines = 4'b0001 << pin;
        endcase
        return lines;
    endfunction

endpackage

// File: rtl/iq_alloc.sv
module iq_alloc #(
    parameter int NUM_ENT = iq_sel_pkg::IQ_ENTRIES,
    parameter int ENQ_W   = iq_sel_pkg::IQ_ENQ_LANES
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic [NUM_ENT-1:0]               vld_q_i,
    input  logic [ENQ_W-1:0]                 enq_vld_i,
    output logic                             enq_ready_o,
    output logic [ENQ_W-1:0][NUM_ENT-1:0]    alloc_oh_o
);

    localparam int CNT_W = $clog2(NUM_ENT + 1);

    logic [CNT_W-1:0]                 free_cnt;
    logic [ENQ_W-1:0][NUM_ENT-1:0]    avail;
    logic [ENQ_W-1:0][NUM_ENT-1:0]    slot_oh;

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            free_cnt = free_cnt + (vld_q_i[i] ? CNT_W'(0) : CNT_W'(1));
        end
    end

    assign enq_ready_o = (free_cnt >= CNT_W'(ENQ_W));
    assign avail[0]    = ~vld_q_i;

    // Each lane peels off the lowest remaining free entry, used or not
    for (genvar k = 0; k < ENQ_W; k++) begin : g_lane
        assign slot_oh[k]    = avail[k] & (~avail[k] + NUM_ENT'(1));
        assign alloc_oh_o[k] = (enq_vld_i[k] && enq_ready_o) ? slot_oh[k] : '0;

        if (k + 1 < ENQ_W) begin : g_next
            assign avail[k+1] = avail[k] & ~slot_oh[k];
        end

        assert_alloc_free_R3: assert property (@(posedge clk_i) disable iff (rst_i)
            $onehot0(alloc_oh_o[k]) && ((alloc_oh_o[k] & vld_q_i) == '0))
            else $error("lane %0d allocated an occupied entry", k);
    end

endmodule

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
    parameter int NUM_ENT = iq_sel_pkg::IQ_ENTRIES,
    parameter int ENQ_W   = iq_sel_pkg::IQ_ENQ_LANES
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic [NUM_ENT-1:0]               vld_q_i,
    input  logic [ENQ_W-1:0][NUM_ENT-1:0]    alloc_oh_i,
    input  logic [NUM_ENT-1:0]               issue_oh_i,
    output logic [NUM_ENT-1:0][NUM_ENT-1:0]  older_o
);

    // older_q[i][j] set: entry j was enqueued before entry i
    logic [NUM_ENT-1:0][NUM_ENT-1:0] older_q, older_d;
    logic [NUM_ENT-1:0]              new_alloc, survivors;
    logic [ENQ_W-1:0][NUM_ENT-1:0]   earlier_lanes;
    logic                            order_bad;

    always_comb begin
        new_alloc = '0;
        for (int k = 0; k < ENQ_W; k++) begin
            new_alloc = new_alloc | alloc_oh_i[k];
        end
        survivors = vld_q_i & ~issue_oh_i;

        earlier_lanes[0] = '0;
        for (int k = 1; k < ENQ_W; k++) begin
            earlier_lanes[k] = earlier_lanes[k-1] | alloc_oh_i[k-1];
        end

        for (int i = 0; i < NUM_ENT; i++) begin
            older_d[i] = older_q[i] & ~issue_oh_i & ~new_alloc;
            for (int k = 0; k < ENQ_W; k++) begin
                if (alloc_oh_i[k][i]) begin
                    older_d[i] = survivors | earlier_lanes[k];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            older_q <= '0;
        end else begin
            older_q <= older_d;
        end
    end

    assign older_o = older_q;

    // Any two occupied entries must be strictly ordered one way
    always_comb begin
        order_bad = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            for (int j = 0; j < NUM_ENT; j++) begin
                if (i != j && vld_q_i[i] && vld_q_i[j] && (older_q[i][j] == older_q[j][i])) begin
                    order_bad = 1'b1;
                end
            end
        end
    end

    assert_age_total_R5: assert property (@(posedge clk_i) disable iff (rst_i) !order_bad)
        else $error("age matrix lost the ordering of two occupied entries");

endmodule

// File: rtl/iq_pair_arbiter.sv
module iq_pair_arbiter #(
    parameter int NUM_ENT = iq_sel_pkg::IQ_ENTRIES,
    parameter int IDX_W   = $clog2(NUM_ENT)
) (
    input  logic                             clk_i,
    input  logic                             rst_i,
    input  logic [NUM_ENT-1:0][NUM_ENT-1:0]  older_i,
    input  logic [NUM_ENT-1:0]               req_a_i,
    input  logic [NUM_ENT-1:0]               req_b_i,
    output logic                             gnt_a_vld_o,
    output logic [IDX_W-1:0]                 gnt_a_idx_o,
    output logic                             gnt_b_vld_o,
    output logic [IDX_W-1:0]                 gnt_b_idx_o,
    output logic [NUM_ENT-1:0]               taken_o
);

    logic [NUM_ENT-1:0] oh_a, oh_b, req_b_left;

    function automatic logic [IDX_W-1:0] encode(logic [NUM_ENT-1:0] oh);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (oh[i]) idx = idx | IDX_W'(i);
        end
        return idx;
    endfunction

    // First slot: requester with no older requester on the same line
    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            oh_a[i] = req_a_i[i] & ~|(older_i[i] & req_a_i);
        end
    end

    assign req_b_left = req_b_i & ~oh_a;

    // Second slot: same rule after removing the first winner
    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            oh_b[i] = req_b_left[i] & ~|(older_i[i] & req_b_left);
        end
    end

    assign gnt_a_vld_o = |oh_a;
    assign gnt_b_vld_o = |oh_b;
    assign gnt_a_idx_o = encode(oh_a);
    assign gnt_b_idx_o = encode(oh_b);
    assign taken_o     = oh_a | oh_b;

    assert_pair_distinct_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (gnt_a_vld_o && gnt_b_vld_o) |-> (gnt_a_idx_o != gnt_b_idx_o))
        else $error("one entry granted to both sub-clusters of a pair");

endmodule

// File: rtl/iq_cluster_select.sv
module iq_cluster_select
    import iq_sel_pkg::*;
#(
    parameter int NUM_ENT = IQ_ENTRIES,
    parameter int ENQ_W   = IQ_ENQ_LANES,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic                                  clk_i,
    input  logic                                  rst_i,
    input  logic [ENQ_W-1:0]                      enq_vld_i,
    input  logic [ENQ_W-1:0][1:0]                 enq_cls_i,
    input  logic [ENQ_W-1:0][1:0]                 enq_pin_i,
    input  logic [ENQ_W-1:0]                      enq_rdy_i,
    output logic                                  enq_ready_o,
    input  logic [NUM_ENT-1:0]                    wake_i,
    output logic [IQ_SUBCLUSTERS-1:0]             gnt_vld_o,
    output logic [IQ_SUBCLUSTERS-1:0][IDX_W-1:0]  gnt_idx_o
);

    logic [NUM_ENT-1:0]                       ent_vld_q, ent_vld_d;
    iq_entry_t [NUM_ENT-1:0]                  ent_q, ent_d;
    logic [NUM_ENT-1:0][NUM_ENT-1:0]          older;
    logic [ENQ_W-1:0][NUM_ENT-1:0]            alloc_oh;
    logic [NUM_ENT-1:0]                       new_alloc, issue_oh;
    logic [NUM_ENT-1:0][IQ_SUBCLUSTERS-1:0]   ent_lines;
    logic [IQ_SUBCLUSTERS-1:0][NUM_ENT-1:0]   req;
    logic [IQ_PAIRS-1:0][NUM_ENT-1:0]         taken;

    // Request lines per sub-cluster from registered entries only
    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            ent_lines[i] = class_lines(ent_q[i].cls, ent_q[i].pin);
            for (int s = 0; s < IQ_SUBCLUSTERS; s++) begin
                req[s][i] = ent_vld_q[i] & ent_q[i].rdy & ent_lines[i][s];
            end
        end
    end

    for (genvar p = 0; p < IQ_PAIRS; p++) begin : g_pair
        iq_pair_arbiter #(
            .NUM_ENT (NUM_ENT),
            .IDX_W   (IDX_W)
        ) u_arb (
            .clk_i       (clk_i),
            .rst_i       (rst_i),
            .older_i     (older),
            .req_a_i     (req[2*p]),
            .req_b_i     (req[2*p+1]),
            .gnt_a_vld_o (gnt_vld_o[2*p]),
            .gnt_a_idx_o (gnt_idx_o[2*p]),
            .gnt_b_vld_o (gnt_vld_o[2*p+1]),
            .gnt_b_idx_o (gnt_idx_o[2*p+1]),
            .taken_o     (taken[p])
        );
    end

    always_comb begin
        issue_oh = '0;
        for (int p = 0; p < IQ_PAIRS; p++) begin
            issue_oh = issue_oh | taken[p];
        end
    end

    iq_alloc #(
        .NUM_ENT (NUM_ENT),
        .ENQ_W   (ENQ_W)
    ) u_alloc (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .vld_q_i     (ent_vld_q),
        .enq_vld_i   (enq_vld_i),
        .enq_ready_o (enq_ready_o),
        .alloc_oh_o  (alloc_oh)
    );

    iq_age_matrix #(
        .NUM_ENT (NUM_ENT),
        .ENQ_W   (ENQ_W)
    ) u_age (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .vld_q_i    (ent_vld_q),
        .alloc_oh_i (alloc_oh),
        .issue_oh_i (issue_oh),
        .older_o    (older)
    );

    always_comb begin
        new_alloc = '0;
        for (int k = 0; k < ENQ_W; k++) begin
            new_alloc = new_alloc | alloc_oh[k];
        end
        ent_vld_d = (ent_vld_q & ~issue_oh) | new_alloc;

        ent_d = ent_q;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (ent_vld_q[i] && wake_i[i]) begin
                ent_d[i].rdy = 1'b1;
            end
            for (int k = 0; k < ENQ_W; k++) begin
                if (alloc_oh[k][i]) begin
                    ent_d[i].rdy = enq_rdy_i[k];
                    ent_d[i].cls = iq_class_e'(enq_cls_i[k]);
                    ent_d[i].pin = enq_pin_i[k];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ent_vld_q <= '0;
            ent_q     <= '0;
        end else begin
            ent_vld_q <= ent_vld_d;
            ent_q     <= ent_d;
        end
    end

    assert_refuse_no_growth_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !enq_ready_o |=> ($countones(ent_vld_q) <= $past($countones(ent_vld_q))))
        else $error("occupancy grew while enqueue was refused");

    for (genvar s = 0; s < IQ_SUBCLUSTERS; s++) begin : g_chk
        assert_issue_frees_R7: assert property (@(posedge clk_i) disable iff (rst_i)
            gnt_vld_o[s] |=> !ent_vld_q[$past(gnt_idx_o[s])])
            else $error("granted entry still occupied on slot %0d", s);

        assert_grant_ready_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            gnt_vld_o[s] |-> (ent_vld_q[gnt_idx_o[s]] && ent_q[gnt_idx_o[s]].rdy))
            else $error("grant on slot %0d to an empty or unready entry", s);
    end

endmodule

// File: tb/iq_cluster_select_tb.sv
`timescale 1ns/1ps
module iq_cluster_select_tb_top;

    localparam int NE = 20;
    localparam int NL = 4;
    localparam int NS = 4;
    localparam int IW = 5;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NL-1:0]         enq_vld = '0;
    logic [NL-1:0][1:0]    enq_cls = '0;
    logic [NL-1:0][1:0]    enq_pin = '0;
    logic [NL-1:0]         enq_rdy = '0;
    logic [NE-1:0]         wake    = '0;
    logic                  enq_ready;
    logic [NS-1:0]         gnt_vld;
    logic [NS-1:0][IW-1:0] gnt_idx;

    always #2 clk = ~clk;

    iq_cluster_select dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .enq_vld_i   (enq_vld),
        .enq_cls_i   (enq_cls),
        .enq_pin_i   (enq_pin),
        .enq_rdy_i   (enq_rdy),
        .enq_ready_o (enq_ready),
        .wake_i      (wake),
        .gnt_vld_o   (gnt_vld),
        .gnt_idx_o   (gnt_idx)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model of the queue
    bit         m_vld [NE];
    bit         m_rdy [NE];
    logic [1:0] m_cls [NE];
    logic [1:0] m_pin [NE];
    int         m_seq [NE];
    int         next_seq = 0;
    int         exp_g [NS];
    bit         exp_ready;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int act_slot(int s);
        return gnt_vld[s] ? int'(gnt_idx[s]) : -1;
    endfunction

    function automatic bit m_line(int i, int s);
        case (m_cls[i])
            2'd0:    return s >= 2;
            2'd1:    return s < 2;
            default: return s == int'(m_pin[i]);
        endcase
    endfunction

    function automatic int m_pick(int s, int excl);
        int best = -1;
        for (int i = 0; i < NE; i++) begin
            if (m_vld[i] && m_rdy[i] && m_line(i, s) && i != excl) begin
                if (best < 0 || m_seq[i] < m_seq[best]) best = i;
            end
        end
        return best;
    endfunction

    task automatic model_expect();
        int nfree = 0;
        exp_g[0] = m_pick(0, -1);
        exp_g[1] = m_pick(1, exp_g[0]);
        exp_g[2] = m_pick(2, -1);
        exp_g[3] = m_pick(3, exp_g[2]);
        for (int i = 0; i < NE; i++) if (!m_vld[i]) nfree++;
        exp_ready = (nfree >= NL);
    endtask

    task automatic model_update(input logic [NL-1:0] ev, input logic [NL-1:0][1:0] ec,
                                input logic [NL-1:0][1:0] ep, input logic [NL-1:0] er,
                                input logic [NE-1:0] wk);
        bit pre [NE];
        int slot [NL];
        int f = 0;
        for (int i = 0; i < NE; i++) pre[i] = m_vld[i];
        for (int k = 0; k < NL; k++) slot[k] = -1;
        for (int i = 0; i < NE; i++) begin
            if (!pre[i] && f < NL) begin
                slot[f] = i;
                f++;
            end
        end
        for (int s = 0; s < NS; s++) if (exp_g[s] >= 0) m_vld[exp_g[s]] = 1'b0;
        for (int i = 0; i < NE; i++) if (pre[i] && wk[i]) m_rdy[i] = 1'b1;
        if (exp_ready) begin
            for (int k = 0; k < NL; k++) begin
                if (ev[k] && slot[k] >= 0) begin
                    m_vld[slot[k]] = 1'b1;
                    m_rdy[slot[k]] = er[k];
                    m_cls[slot[k]] = ec[k];
                    m_pin[slot[k]] = ep[k];
                    m_seq[slot[k]] = next_seq;
                    next_seq++;
                end
            end
        end
    endtask

    // One cycle: compare, drive, recheck (R9), clock, update model
    task automatic step(input logic [NL-1:0] ev, input logic [NL-1:0][1:0] ec,
                        input logic [NL-1:0][1:0] ep, input logic [NL-1:0] er,
                        input logic [NE-1:0] wk);
        model_expect();
        for (int s = 0; s < NS; s++)
            chk(act_slot(s) == exp_g[s], (s % 2 == 0) ? "R5 oldest first" : "R6 second pick",
                act_slot(s), exp_g[s]);
        chk(enq_ready == exp_ready, "R2 enqueue acceptance", int'(enq_ready), int'(exp_ready));
        enq_vld = ev;
        enq_cls = ec;
        enq_pin = ep;
        enq_rdy = er;
        wake    = wk;
        #1;
        for (int s = 0; s < NS; s++)
            chk(act_slot(s) == exp_g[s], "R9 grant independent of inputs", act_slot(s), exp_g[s]);
        @(posedge clk);
        model_update(ev, ec, ep, er, wk);
        @(negedge clk);
    endtask

    task automatic idle(input logic [NE-1:0] wk);
        step('0, '0, '0, '0, wk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int total;
        void'($urandom(32'd20431));
        for (int i = 0; i < NE; i++) begin
            m_vld[i] = 1'b0; m_rdy[i] = 1'b0; m_cls[i] = '0; m_pin[i] = '0; m_seq[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(gnt_vld == '0, "R1 reset no grants", int'(gnt_vld), 0);
        chk(enq_ready == 1'b1, "R1 reset accepts", int'(enq_ready), 1);

        // Lane 0 lower class into an empty queue
        step(4'b0001, {2'd0, 2'd0, 2'd0, 2'd0}, '0, 4'b0001, '0);
        chk(act_slot(2) == 0, "R3 first free entry", act_slot(2), 0);

        // Pinned lanes 0,2,3 with lane 1 idle; entry 0 still occupied
        step(4'b1101, {2'd2, 2'd2, 2'd2, 2'd2}, {2'd3, 2'd1, 2'd0, 2'd0}, 4'b1111, '0);
        chk(act_slot(0) == 1, "R3 lane0 slot", act_slot(0), 1);
        chk(act_slot(1) == 3, "R4 pinned U1", act_slot(1), 3);
        chk(act_slot(3) == 4, "R3 idle lane consumes slot", act_slot(3), 4);
        chk(act_slot(2) == -1, "R7 issued entry gone", act_slot(2), -1);

        // Lower, pinned L0, upper, upper
        step(4'b1111, {2'd1, 2'd1, 2'd2, 2'd0}, {2'd0, 2'd0, 2'd2, 2'd0}, 4'b1111, '0);
        chk(act_slot(2) == 0, "R4 lower class on L0", act_slot(2), 0);
        chk(act_slot(3) == -1, "R6 pinned L0 not on L1", act_slot(3), -1);
        chk(act_slot(0) == 5 && act_slot(1) == 6, "R4 upper class", act_slot(0), 5);
        idle('0);
        chk(act_slot(2) == 2, "R7 no regrant of entry 0", act_slot(2), 2);

        // Four grants in one cycle
        step(4'b1111, {2'd1, 2'd1, 2'd0, 2'd0}, '0, 4'b1111, '0);
        chk($countones(gnt_vld) == 4, "R10 four issues", $countones(gnt_vld), 4);
        idle('0);

        // Not-ready entries woken youngest first
        step(4'b1111, {2'd1, 2'd1, 2'd1, 2'd1}, '0, 4'b0000, '0);
        chk(gnt_vld == '0, "R8 unready not granted", int'(gnt_vld), 0);
        idle(20'h00008);
        chk(act_slot(0) == 3, "R8 wake makes ready", act_slot(0), 3);
        idle(20'h00007);
        chk(act_slot(0) == 0 && act_slot(1) == 1, "R5 age after wake", act_slot(0), 0);
        idle('0);
        chk(act_slot(0) == 2, "R5 remaining oldest", act_slot(0), 2);
        idle('0);

        // Fill to one short of the threshold, then offer a refused group
        repeat (4) step(4'b1111, '0, '0, 4'b0000, '0);
        step(4'b0001, '0, '0, 4'b0000, '0);
        chk(enq_ready == 1'b0, "R2 refused near full", int'(enq_ready), 0);
        step(4'b1111, '0, '0, 4'b1111, '0);
        total = 0;
        for (int n = 0; n < 12; n++) begin
            idle((n == 0) ? {NE{1'b1}} : '0);
            total += $countones(gnt_vld);
        end
        chk(total == 17, "R2 refused lanes ignored", total, 17);

        // Seeded random traffic
        for (int c = 0; c < 3000; c++) begin
            logic [NL-1:0]      ev, er;
            logic [NL-1:0][1:0] ec, ep;
            logic [NE-1:0]      wk;
            ev = NL'($urandom);
            for (int k = 0; k < NL; k++) begin
                ec[k] = 2'($urandom % 4);
                ep[k] = 2'($urandom % 4);
                er[k] = ($urandom % 3) != 0;
            end
            for (int i = 0; i < NE; i++) wk[i] = ($urandom % 8) == 0;
            step(ev, ec, ep, er, wk);
        end

        for (int n = 0; n < 15; n++) idle({NE{1'b1}});
        chk(gnt_vld == '0, "R7 queue drained", int'(gnt_vld), 0);
        chk(enq_ready == 1'b1, "R2 accepts when drained", int'(enq_ready), 1);
        finish_run();
    end

endmodule